// File: doc/BRIEF.md
# Pipelined Store Path with Delayed Write Buffer

This block is the store path of a direct-mapped data cache. It splits each store across two cycles. In the cycle a store arrives, only its tag is checked. Its data is parked in a one-entry delayed write buffer. The data array is written one store later, in the same cycle that the next store has its tag checked. Tag checking and array writing therefore overlap, and a store never needs the tag and data arrays in the same cycle for itself.

Loads read the data array in the same cycle they are presented. Every load also compares its line index and word offset against the delayed write buffer. When the buffer holds a write to the same word, the load gets merged data: buffered bytes where the byte enables are set, and array bytes everywhere else. This costs no extra cycle.

On a tag mismatch, the block raises miss and stall and drains any pending buffered write into the array, which leaves the store pipeline empty. The requester holds its request while stall is high. An outside refill agent updates the tag array. The retried request then hits.

Top module: `dly_store_pipe`

## Requirements
- R1: Reset, asserted asynchronously, empties the delayed write buffer. While reset is low, and for the first store hit after release, no data array write is issued.
- R2: When a store hits and the buffer is valid, the block issues a data array write in that same cycle. The write carries the buffered store's index, word, data and byte enables. The arriving store takes the buffer's place.
- R3: A store that hits while the buffer is empty issues no data array write in its own cycle.
- R4: Loads and idle cycles leave the buffer untouched. The next store hit writes the entry that was buffered before them.
- R5: A load whose index and word match a valid buffer entry gets merged data: the buffered byte where its enable bit is set, the array byte otherwise. Byte k covers data bits 8k+7..8k. The load reports hit=1 and stall=0.
- R6: A load that does not match the buffer returns the array word unchanged.
- R7: A valid request whose tag differs from the stored tag, or whose line is marked invalid, raises miss=1 and stall=1 with hit=0.
- R8: In a miss cycle the pending buffer entry, if any, is written to the array, and the buffer is then empty.
- R9: A store that misses is not placed in the buffer.
- R10: The address splits, from the top down, into tag, line index, word offset and byte offset. The tag and data read ports are driven with the request's index and word in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_store | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Store data |
| req_be | input | DATA_W/8 | Store byte enables |
| tag_rd_idx | output | IDX_W | Tag array read index |
| tag_rd_tag | input | TAG_W | Stored tag for tag_rd_idx |
| tag_rd_valid | input | 1 | Stored line valid |
| data_rd_idx | output | IDX_W | Data array read index |
| data_rd_word | output | WORD_W | Data array read word |
| data_rd_data | input | DATA_W | Data array read word value |
| data_wr_en | output | 1 | Data array write strobe |
| data_wr_idx | output | IDX_W | Write index |
| data_wr_word | output | WORD_W | Write word |
| data_wr_data | output | DATA_W | Write data |
| data_wr_be | output | DATA_W/8 | Write byte enables |
| hit | output | 1 | Request tag matched |
| miss | output | 1 | Request tag did not match |
| stall | output | 1 | Requester must hold the request |
| load_data | output | DATA_W | Load result (merged with buffer) |

## Verification
The bench builds the block with its defaults: a 12-bit address, 32-bit words, 16 lines and 4 words per line. That gives a 4-bit tag and four byte lanes. Sixty-four array words keep the bench's own array model small. Four byte lanes make partial-enable merges and drains observable. The four words per line let a load share an index with the buffered store but sit on a different word, which exercises the word comparison separately from the index comparison.

// File: rtl/ps_pkg.sv
package ps_pkg;
  localparam int unsigned PS_ADDR_W = 12;
  localparam int unsigned PS_DATA_W = 32;
  localparam int unsigned PS_IDX_W  = 4;
  localparam int unsigned PS_WORD_W = 2;

  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,
    ACT_FILL  = 2'd1,
    ACT_DRAIN = 2'd2
  } buf_act_e;
endpackage

// File: rtl/ps_addr_split.sv
module ps_addr_split #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned WORD_W = 2,
  parameter int unsigned BOFF_W = 2,
  localparam int unsigned TAG_W = ADDR_W - IDX_W - WORD_W - BOFF_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [TAG_W-1:0]  tag,
  output logic [IDX_W-1:0]  idx,
  output logic [WORD_W-1:0] word
);
  logic [BOFF_W-1:0] boff_unused;

  assign {tag, idx, word, boff_unused} = addr;
endmodule

// File: rtl/ps_tag_check.sv
module ps_tag_check #(
  parameter int unsigned TAG_W = 4
) (
  input  logic             req_valid,
  input  logic [TAG_W-1:0] req_tag,
  input  logic [TAG_W-1:0] line_tag,
  input  logic             line_valid,
  output logic             hit,
  output logic             miss
);
  logic match;

  assign match = line_valid && (line_tag == req_tag);
  assign hit   = req_valid && match;
  assign miss  = req_valid && !match;
endmodule

// File: rtl/ps_dwb.sv
module ps_dwb
  import ps_pkg::*;
#(
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned WORD_W = 2,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned BE_W  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  buf_act_e          act,
  input  logic [IDX_W-1:0]  in_idx,
  input  logic [WORD_W-1:0] in_word,
  input  logic [DATA_W-1:0] in_data,
  input  logic [BE_W-1:0]   in_be,
  output logic              q_valid,
  output logic [IDX_W-1:0]  q_idx,
  output logic [WORD_W-1:0] q_word,
  output logic [DATA_W-1:0] q_data,
  output logic [BE_W-1:0]   q_be
);
  logic valid_d;
  logic fill_en;

  assign fill_en = (act == ACT_FILL);

  always_comb begin
    valid_d = q_valid;
    case (act)
      ACT_FILL:  valid_d = 1'b1;
      ACT_DRAIN: valid_d = 1'b0;
      default:   valid_d = q_valid;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
    end else begin
      q_valid <= valid_d;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      q_idx  <= in_idx;
      q_word <= in_word;
      q_data <= in_data;
      q_be   <= in_be;
    end
  end
endmodule

// File: rtl/ps_byte_merge.sv
module ps_byte_merge #(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned BE_W  = DATA_W / 8
) (
  input  logic [DATA_W-1:0] base,
  input  logic [DATA_W-1:0] over,
  input  logic [BE_W-1:0]   sel,
  output logic [DATA_W-1:0] result
);
  for (genvar b = 0; b < BE_W; b++) begin : g_lane
    assign result[8*b +: 8] = sel[b] ? over[8*b +: 8] : base[8*b +: 8];
  end
endmodule

// File: rtl/dly_store_pipe.sv
module dly_store_pipe
  import ps_pkg::*;
#(
  parameter int unsigned ADDR_W = PS_ADDR_W,
  parameter int unsigned DATA_W = PS_DATA_W,
  parameter int unsigned IDX_W  = PS_IDX_W,
  parameter int unsigned WORD_W = PS_WORD_W,
  localparam int unsigned BE_W   = DATA_W / 8,
  localparam int unsigned BOFF_W = $clog2(BE_W),
  localparam int unsigned TAG_W  = ADDR_W - IDX_W - WORD_W - BOFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_store,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [BE_W-1:0]   req_be,
  output logic [IDX_W-1:0]  tag_rd_idx,
  input  logic [TAG_W-1:0]  tag_rd_tag,
  input  logic              tag_rd_valid,
  output logic [IDX_W-1:0]  data_rd_idx,
  output logic [WORD_W-1:0] data_rd_word,
  input  logic [DATA_W-1:0] data_rd_data,
  output logic              data_wr_en,
  output logic [IDX_W-1:0]  data_wr_idx,
  output logic [WORD_W-1:0] data_wr_word,
  output logic [DATA_W-1:0] data_wr_data,
  output logic [BE_W-1:0]   data_wr_be,
  output logic              hit,
  output logic              miss,
  output logic              stall,
  output logic [DATA_W-1:0] load_data
);
  logic [TAG_W-1:0]  a_tag;
  logic [IDX_W-1:0]  a_idx;
  logic [WORD_W-1:0] a_word;
  logic              store_hit;
  logic              buf_match;
  logic [BE_W-1:0]   merge_sel;
  buf_act_e          act;
  logic              b_valid;
  logic [IDX_W-1:0]  b_idx;
  logic [WORD_W-1:0] b_word;
  logic [DATA_W-1:0] b_data;
  logic [BE_W-1:0]   b_be;

  ps_addr_split #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .WORD_W(WORD_W), .BOFF_W(BOFF_W)
  ) u_split (
    .addr(req_addr), .tag(a_tag), .idx(a_idx), .word(a_word)
  );

  assign tag_rd_idx   = a_idx;
  assign data_rd_idx  = a_idx;
  assign data_rd_word = a_word;

  ps_tag_check #(.TAG_W(TAG_W)) u_tchk (
    .req_valid (req_valid),
    .req_tag   (a_tag),
    .line_tag  (tag_rd_tag),
    .line_valid(tag_rd_valid),
    .hit       (hit),
    .miss      (miss)
  );

  assign stall     = miss;
  assign store_hit = hit && req_store;

  always_comb begin
    act = ACT_NONE;
    if (store_hit) begin
      act = ACT_FILL;
    end else if (miss) begin
      act = ACT_DRAIN;
    end
  end

  ps_dwb #(.IDX_W(IDX_W), .WORD_W(WORD_W), .DATA_W(DATA_W)) u_dwb (
    .clk    (clk),
    .rst_n  (rst_n),
    .act    (act),
    .in_idx (a_idx),
    .in_word(a_word),
    .in_data(req_wdata),
    .in_be  (req_be),
    .q_valid(b_valid),
    .q_idx  (b_idx),
    .q_word (b_word),
    .q_data (b_data),
    .q_be   (b_be)
  );

  assign data_wr_en   = b_valid && (act != ACT_NONE);
  assign data_wr_idx  = b_idx;
  assign data_wr_word = b_word;
  assign data_wr_data = b_data;
  assign data_wr_be   = b_be;

  assign buf_match = b_valid && (b_idx == a_idx) && (b_word == a_word);
  assign merge_sel = buf_match ? b_be : '0;

  ps_byte_merge #(.DATA_W(DATA_W)) u_merge (
    .base  (data_rd_data),
    .over  (b_data),
    .sel   (merge_sel),
    .result(load_data)
  );
endmodule

// File: rtl/ps_store_chk.sv
module ps_store_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_store,
  input logic [DATA_W-1:0] req_wdata,
  input logic              hit,
  input logic              miss,
  input logic              stall,
  input logic              data_wr_en,
  input logic [DATA_W-1:0] data_wr_data
);
  // R7
  miss_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss |-> (stall && !hit));

  // R8
  drain_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss |=> !data_wr_en);

  // R2
  store_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_store && hit) |=>
      (!(req_valid && req_store && hit) ||
       (data_wr_en && (data_wr_data == $past(req_wdata)))));

  // R5
  load_nostall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_store && hit) |-> !stall);

  // R4
  wr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr_en |-> (req_valid && ((req_store && hit) || miss)));
endmodule

bind dly_store_pipe ps_store_chk #(.DATA_W(DATA_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_store   (req_store),
  .req_wdata   (req_wdata),
  .hit         (hit),
  .miss        (miss),
  .stall       (stall),
  .data_wr_en  (data_wr_en),
  .data_wr_data(data_wr_data)
);

// File: tb/dly_store_pipe_tb_top.sv
module dly_store_pipe_tb_top;
  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_store;
  logic [11:0] req_addr;
  logic [31:0] req_wdata;
  logic [3:0]  req_be;
  logic [3:0]  tag_rd_idx;
  logic [3:0]  tag_rd_tag;
  logic        tag_rd_valid;
  logic [3:0]  data_rd_idx;
  logic [1:0]  data_rd_word;
  logic [31:0] data_rd_data;
  logic        data_wr_en;
  logic [3:0]  data_wr_idx;
  logic [1:0]  data_wr_word;
  logic [31:0] data_wr_data;
  logic [3:0]  data_wr_be;
  logic        hit;
  logic        miss;
  logic        stall;
  logic [31:0] load_data;

  int n_chk;
  int n_fail;
  bit done;

  logic [3:0]  tmem [16];
  logic [31:0] dmem [64];

  dly_store_pipe dut_i (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  assign tag_rd_tag   = tmem[tag_rd_idx];
  assign tag_rd_valid = 1'b1;
  assign data_rd_data = dmem[{data_rd_idx, data_rd_word}];

  always @(posedge clk) begin
    if (data_wr_en) begin
      for (int b = 0; b < 4; b++) begin
        if (data_wr_be[b]) dmem[{data_wr_idx, data_wr_word}][8*b +: 8] <= data_wr_data[8*b +: 8];
      end
    end
  end

  typedef struct packed {
    logic        vld;
    logic        st;
    logic [3:0]  tg;
    logic [3:0]  ix;
    logic [1:0]  wd;
    logic [31:0] wdat;
    logic [3:0]  be;
    logic        e_hit;
    logic        e_wr;
    logic [31:0] e_wdat;
    logic [31:0] e_ld;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b1, 4'h3, 4'h1, 2'd0, 32'h1111_1111, 4'hF, 1'b1, 1'b0, 32'h0,         32'h0},          // R3
    '{1'b1, 1'b1, 4'h3, 4'h2, 2'd1, 32'h2222_2222, 4'h3, 1'b1, 1'b1, 32'h1111_1111, 32'h0},          // R2
    '{1'b1, 1'b0, 4'h3, 4'h2, 2'd1, 32'h0,         4'h0, 1'b1, 1'b0, 32'h0,         32'hA000_2222},  // R5
    '{1'b1, 1'b0, 4'h3, 4'h1, 2'd0, 32'h0,         4'h0, 1'b1, 1'b0, 32'h0,         32'h1111_1111},  // R6
    '{1'b0, 1'b0, 4'h3, 4'h0, 2'd0, 32'h0,         4'h0, 1'b0, 1'b0, 32'h0,         32'h0},          // R4 idle
    '{1'b1, 1'b1, 4'h3, 4'h5, 2'd3, 32'h5555_5555, 4'hC, 1'b1, 1'b1, 32'h2222_2222, 32'h0},          // R4
    '{1'b1, 1'b1, 4'h7, 4'h6, 2'd0, 32'h9999_9999, 4'hF, 1'b0, 1'b1, 32'h5555_5555, 32'h0},          // R7 R8
    '{1'b1, 1'b1, 4'h3, 4'h6, 2'd0, 32'h6666_6666, 4'hF, 1'b1, 1'b0, 32'h0,         32'h0},          // R9
    '{1'b1, 1'b0, 4'h3, 4'h5, 2'd3, 32'h0,         4'h0, 1'b1, 1'b0, 32'h0,         32'h5555_0017},  // R8 landed
    '{1'b1, 1'b0, 4'h9, 4'h0, 2'd0, 32'h0,         4'h0, 1'b0, 1'b1, 32'h6666_6666, 32'h0},          // R7 R8
    '{1'b1, 1'b1, 4'h3, 4'h0, 2'd2, 32'h7777_7777, 4'hF, 1'b1, 1'b0, 32'h0,         32'h0}           // R8 empty
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic s, input logic [3:0] tg, input logic [3:0] ix,
                       input logic [1:0] wd, input logic [31:0] d, input logic [3:0] be);
    req_valid = v;
    req_store = s;
    req_addr  = {tg, ix, wd, 2'b00};
    req_wdata = d;
    req_be    = be;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    n_chk = 0;
    n_fail = 0;
    done = 1'b0;
    for (int i = 0; i < 16; i++) tmem[i] = 4'h3;
    for (int i = 0; i < 64; i++) dmem[i] = 32'hA000_0000 | i;
    rst_n = 1'b0;
    drive(1'b0, 1'b0, 4'h0, 4'h0, 2'd0, 32'h0, 4'h0);
    repeat (3) @(negedge clk);
    #2;
    chk("R1 reset wr_en", {31'b0, data_wr_en}, 32'h0);
    chk("R1 reset miss", {31'b0, miss}, 32'h0);
    chk("R1 reset hit", {31'b0, hit}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      @(negedge clk);
      drive(v.vld, v.st, v.tg, v.ix, v.wd, v.wdat, v.be);
      #2;
      chk($sformatf("R7 vec%0d hit", i), {31'b0, hit}, {31'b0, v.e_hit});
      chk($sformatf("R7 vec%0d miss", i), {31'b0, miss}, {31'b0, v.vld && !v.e_hit});
      chk($sformatf("R7 vec%0d stall", i), {31'b0, stall}, {31'b0, v.vld && !v.e_hit});
      chk($sformatf("R2 vec%0d wr_en", i), {31'b0, data_wr_en}, {31'b0, v.e_wr});
      if (v.e_wr) chk($sformatf("R8 vec%0d wr_data", i), data_wr_data, v.e_wdat);
      if (v.vld && !v.st && v.e_hit) chk($sformatf("R5 R6 vec%0d load", i), load_data, v.e_ld);
    end

    // R10: read ports follow the request fields
    @(negedge clk);
    drive(1'b0, 1'b1, 4'h3, 4'h9, 2'd2, 32'h0, 4'h0);
    #2;
    chk("R10 tag_rd_idx", {28'b0, tag_rd_idx}, 32'h9);
    chk("R10 data_rd_idx", {28'b0, data_rd_idx}, 32'h9);
    chk("R10 data_rd_word", {30'b0, data_rd_word}, 32'h2);

    // R5: load same index, different word gets no merge (buffer holds i0 w2)
    @(negedge clk);
    drive(1'b1, 1'b0, 4'h3, 4'h0, 2'd1, 32'h0, 4'h0);
    #2;
    chk("R5 word mismatch load", load_data, 32'hA000_0001);
    drive(1'b1, 1'b0, 4'h3, 4'h0, 2'd2, 32'h0, 4'h0);
    #2;
    chk("R5 full merge load", load_data, 32'h7777_7777);

    // R1: reset mid-run drops the buffered store
    @(negedge clk);
    drive(1'b1, 1'b1, 4'h3, 4'hA, 2'd0, 32'hBBBB_BBBB, 4'hF);
    rst_n = 1'b0;
    #2;
    chk("R1 in-reset wr_en", {31'b0, data_wr_en}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    chk("R1 first store after reset wr_en", {31'b0, data_wr_en}, 32'h0);
    @(negedge clk);
    drive(1'b0, 1'b0, 4'h0, 4'h0, 2'd0, 32'h0, 4'h0);
    #2;
    chk("R3 idle wr_en", {31'b0, data_wr_en}, 32'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule